// File: doc/BRIEF.md
# SMBus Slave Register Interface

This block is the serial front end of a charger controller. It listens to the open-drain SCL and SDA lines of a two-wire bus as a slave and never starts traffic itself. Both lines are first resynchronised into the system clock and cleaned of short glitches. The block then finds START and STOP conditions and answers one fixed 7-bit address. After the address it takes a command byte and 16-bit words. It supports a word write (address+W, command, low byte, high byte) and a word read (address+W, command, repeated START, address+R, then two bytes returned low byte first).

A written word is not applied when its last byte arrives. It is held in a staging register and goes into the register file only when the STOP that closes the transaction is seen. A START that arrives before that STOP throws the staged word away. The register file holds a parameter-set number of writable 16-bit words, and its contents are available in parallel to the charger logic. Two command codes read fixed identity words: 0x0006 for the device and 0x004D for the manufacturer. Writes to those two codes are accepted on the bus and have no effect. The block drives SDA only by pulling it low.

Top module: `smb_slave_regs`

## Requirements
- R1: Only address byte 0x12 (write) or 0x13 (read), that is 7-bit address 0x09 followed by the R/W bit, is acknowledged. Any other address gets no acknowledge, and SDA is not pulled low again until the next START.
- R2: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. Data bits are taken on SCL rising edges, most significant bit first, in both directions.
- R3: Each accepted byte is acknowledged by pulling SDA low through the ninth clock. These are a matching address, a known command, and the low and high data bytes. A third data byte in a write gets no acknowledge.
- R4: A write-word changes the register file only after the closing STOP. Until then the parallel register outputs keep their old values.
- R5: A START that comes after a complete write-word but before any STOP discards the staged word, and the register stays unchanged.
- R6: A read-word returns the addressed word as the low byte and then the high byte. The slave goes on to the high byte only when the master acknowledges the low byte.
- R7: Command 0xFE reads 0x0006 and command 0xFF reads 0x004D.
- R8: A write-word to command 0xFE or 0xFF is acknowledged but changes no register, and both identity words still read back unchanged.
- R9: A command code that is neither below NUM_REGS (writable codes 0..NUM_REGS-1) nor 0xFE/0xFF gets no acknowledge, and the data bytes that follow are not acknowledged.
- R10: An address byte with R/W=1 gets no acknowledge when no command byte was accepted since the last STOP.
- R11: An SCL pulse shorter than FILT_LEN system clocks is not counted as a bus clock.
- R12: After reset every register reads zero and SDA is released. SDA is never pulled low while the bus is idle between a STOP and the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NUM_REGS*16 | Writable registers, register k in bits 16k+15..16k |

## Verification
The hardest case to reach is a repeated START that lands after a full write-word has been staged but before its STOP. To get there, the bench master sends both data bytes and then turns the usual STOP into a second START. It then checks the parallel outputs and reads the register back to confirm nothing was applied. The other hard case is a short SCL glitch in the middle of a byte. The master inserts a two-clock SCL pulse while SCL is low and then expects the byte to arrive intact.

// File: rtl/smb_pkg.sv
package smb_pkg;

   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      LNK_IDLE,
      LNK_RX,
      LNK_TX
   } lnk_mode_t;

   typedef enum logic [2:0] {
      BY_ADDR,
      BY_CMD,
      BY_DLO,
      BY_DHI,
      BY_EXTRA
   } byte_kind_t;

   function automatic byte_kind_t next_kind(input byte_kind_t k);
      case (k)
         BY_ADDR: next_kind = BY_CMD;
         BY_CMD:  next_kind = BY_DLO;
         BY_DLO:  next_kind = BY_DHI;
         default: next_kind = BY_EXTRA;
      endcase
   endfunction

endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_o
);
   localparam int CW = $clog2(FILT_LEN + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt_q;
   logic                   out_q;
   logic                   samp;

   assign samp  = sync_q[SYNC_STAGES-1];
   assign pin_o = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
   end

   // output follows the synchronised pin only after FILT_LEN agreeing samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b1;
      end else if (samp == out_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
         cnt_q <= '0;
         out_q <= samp;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assert_filter_follows_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> ($past(samp) == out_q));

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
   parameter int          NUM_REGS   = 4,
   parameter logic [15:0] RST_VAL    = 16'h0000,
   parameter logic [7:0]  CMD_DEV_ID = 8'hFE,
   parameter logic [7:0]  CMD_MFR_ID = 8'hFF,
   parameter logic [15:0] DEV_ID_VAL = 16'h0006,
   parameter logic [15:0] MFR_ID_VAL = 16'h004D
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit_i,
   input  logic [7:0]             cmd_i,
   input  logic [15:0]            wdata_i,
   output logic [15:0]            rd_data_o,
   output logic [NUM_REGS*16-1:0] regs_o
);
   localparam logic [7:0] NREG8 = 8'(NUM_REGS);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [15:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= RST_VAL;
         end else if (commit_i && cmd_i == 8'(g)) begin
            word_q <= wdata_i;
         end
      end
      assign regs_o[g*16 +: 16] = word_q;
   end

   always_comb begin
      rd_data_o = '0;
      if (cmd_i == CMD_DEV_ID) begin
         rd_data_o = DEV_ID_VAL;
      end else if (cmd_i == CMD_MFR_ID) begin
         rd_data_o = MFR_ID_VAL;
      end else begin
         for (int k = 0; k < NUM_REGS; k++) begin
            if (cmd_i == 8'(k)) rd_data_o = regs_o[k*16 +: 16];
         end
      end
   end

   assert_commit_writable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (cmd_i < NREG8));

   assert_hold_without_commit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(regs_o));

endmodule

// File: rtl/smb_link.sv
module smb_link
   import smb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h09,
   parameter int         NUM_REGS   = 4,
   parameter logic [7:0] CMD_DEV_ID = 8'hFE,
   parameter logic [7:0] CMD_MFR_ID = 8'hFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_f,
   input  logic        sda_f,
   input  logic [15:0] rd_data_i,
   output logic [7:0]  cmd_o,
   output logic        commit_o,
   output logic [15:0] wdata_o,
   output logic        sda_oe_o
);
   localparam logic [7:0] NREG8 = 8'(NUM_REGS);

   function automatic logic cmd_known(input logic [7:0] c);
      cmd_known = (c < NREG8) || (c == CMD_DEV_ID) || (c == CMD_MFR_ID);
   endfunction

   lnk_mode_t   mode_q;
   byte_kind_t  kind_q;
   logic [3:0]  bitcnt_q;
   logic [7:0]  rx_sr_q, tx_sr_q, cmd_q, lo_q, hi_q;
   logic        scl_d, sda_d, oe_q, cmd_ok_q, staged_q, go_tx_q, txhi_q, mack_q, commit_q;
   logic        start_ev, stop_ev, rise, fall, rx_ack;

   assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
   assign rise     = scl_f & ~scl_d;
   assign fall     = ~scl_f & scl_d;

   always_comb begin
      case (kind_q)
         BY_ADDR: rx_ack = (rx_sr_q[7:1] == DEV_ADDR) && (!rx_sr_q[0] || cmd_ok_q);
         BY_CMD:  rx_ack = cmd_known(rx_sr_q);
         BY_DLO:  rx_ack = 1'b1;
         BY_DHI:  rx_ack = 1'b1;
         default: rx_ack = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
         mode_q   <= LNK_IDLE;
         kind_q   <= BY_ADDR;
         bitcnt_q <= '0;
         rx_sr_q  <= '0;
         tx_sr_q  <= '0;
         cmd_q    <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         oe_q     <= 1'b0;
         cmd_ok_q <= 1'b0;
         staged_q <= 1'b0;
         go_tx_q  <= 1'b0;
         txhi_q   <= 1'b0;
         mack_q   <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         scl_d    <= scl_f;
         sda_d    <= sda_f;
         commit_q <= 1'b0;
         if (start_ev) begin
            mode_q   <= LNK_RX;
            kind_q   <= BY_ADDR;
            bitcnt_q <= '0;
            staged_q <= 1'b0;
            go_tx_q  <= 1'b0;
            oe_q     <= 1'b0;
         end else if (stop_ev) begin
            mode_q   <= LNK_IDLE;
            oe_q     <= 1'b0;
            commit_q <= staged_q && (cmd_q < NREG8);
            staged_q <= 1'b0;
            cmd_ok_q <= 1'b0;
         end else if (mode_q == LNK_RX) begin
            if (rise) begin
               if (bitcnt_q < 4'd8) rx_sr_q <= {rx_sr_q[6:0], sda_f};
               if (bitcnt_q != 4'd9) bitcnt_q <= bitcnt_q + 4'd1;
            end else if (fall) begin
               if (bitcnt_q == 4'd8) begin
                  if (rx_ack) begin
                     oe_q <= 1'b1;
                     case (kind_q)
                        BY_ADDR: go_tx_q <= rx_sr_q[0];
                        BY_CMD: begin
                           cmd_q    <= rx_sr_q;
                           cmd_ok_q <= 1'b1;
                        end
                        BY_DLO: lo_q <= rx_sr_q;
                        BY_DHI: begin
                           hi_q     <= rx_sr_q;
                           staged_q <= 1'b1;
                        end
                        default: ;
                     endcase
                  end else begin
                     mode_q <= LNK_IDLE;
                     oe_q   <= 1'b0;
                  end
               end else if (bitcnt_q == 4'd9) begin
                  bitcnt_q <= '0;
                  if (go_tx_q) begin
                     mode_q  <= LNK_TX;
                     tx_sr_q <= rd_data_i[7:0];
                     txhi_q  <= 1'b0;
                     oe_q    <= ~rd_data_i[7];
                  end else begin
                     oe_q   <= 1'b0;
                     kind_q <= next_kind(kind_q);
                  end
               end
            end
         end else if (mode_q == LNK_TX) begin
            if (rise) begin
               if (bitcnt_q == 4'd8) mack_q <= ~sda_f;
               if (bitcnt_q != 4'd9) bitcnt_q <= bitcnt_q + 4'd1;
            end else if (fall) begin
               if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd7) begin
                  tx_sr_q <= {tx_sr_q[6:0], 1'b0};
                  oe_q    <= ~tx_sr_q[6];
               end else if (bitcnt_q == 4'd8) begin
                  oe_q <= 1'b0;
               end else if (bitcnt_q == 4'd9) begin
                  if (!txhi_q && mack_q) begin
                     tx_sr_q  <= rd_data_i[15:8];
                     txhi_q   <= 1'b1;
                     bitcnt_q <= '0;
                     oe_q     <= ~rd_data_i[15];
                  end else begin
                     mode_q <= LNK_IDLE;
                     oe_q   <= 1'b0;
                  end
               end
            end
         end
      end
   end

   assign cmd_o    = cmd_q;
   assign commit_o = commit_q;
   assign wdata_o  = {hi_q, lo_q};
   assign sda_oe_o = oe_q;

   assert_idle_released_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LNK_IDLE) |-> !sda_oe_o);

   assert_foreign_addr_nack_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (fall && mode_q == LNK_RX && kind_q == BY_ADDR && bitcnt_q == 4'd8 &&
       rx_sr_q[7:1] != DEV_ADDR && !start_ev && !stop_ev) |=> !sda_oe_o);

   assert_unknown_cmd_nack_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (fall && mode_q == LNK_RX && kind_q == BY_CMD && bitcnt_q == 4'd8 &&
       !cmd_known(rx_sr_q) && !start_ev && !stop_ev) |=> !sda_oe_o);

   assert_start_drops_stage_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !staged_q);

   assert_commit_after_stop_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_ev));

endmodule

// File: rtl/smb_slave_regs.sv
module smb_slave_regs #(
   parameter logic [6:0]  DEV_ADDR    = 7'h09,
   parameter int          NUM_REGS    = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int          FILT_LEN    = 3,
   parameter logic [15:0] RST_VAL     = 16'h0000,
   parameter logic [7:0]  CMD_DEV_ID  = 8'hFE,
   parameter logic [7:0]  CMD_MFR_ID  = 8'hFF,
   parameter logic [15:0] DEV_ID_VAL  = 16'h0006,
   parameter logic [15:0] MFR_ID_VAL  = 16'h004D
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_drive_low_o,
   output logic [NUM_REGS*16-1:0] regs_o
);
   localparam int NLINES = 2;

   if (NUM_REGS < 1 || NUM_REGS > 250) begin : g_bad_nregs
      $error("NUM_REGS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end
   if (int'(CMD_DEV_ID) < NUM_REGS || int'(CMD_MFR_ID) < NUM_REGS || CMD_DEV_ID == CMD_MFR_ID) begin : g_bad_cmd
      $error("identity command codes collide");
   end

   logic [NLINES-1:0] raw, filt;
   logic [7:0]        cmd;
   logic              commit;
   logic [15:0]       wdata, rd_data;

   assign raw = {sda_i, scl_i};

   for (genvar l = 0; l < NLINES; l++) begin : g_line
      smb_pin_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_i (raw[l]),
         .pin_o (filt[l])
      );
   end

   smb_link #(
      .DEV_ADDR   (DEV_ADDR),
      .NUM_REGS   (NUM_REGS),
      .CMD_DEV_ID (CMD_DEV_ID),
      .CMD_MFR_ID (CMD_MFR_ID)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (filt[0]),
      .sda_f     (filt[1]),
      .rd_data_i (rd_data),
      .cmd_o     (cmd),
      .commit_o  (commit),
      .wdata_o   (wdata),
      .sda_oe_o  (sda_drive_low_o)
   );

   smb_regfile #(
      .NUM_REGS   (NUM_REGS),
      .RST_VAL    (RST_VAL),
      .CMD_DEV_ID (CMD_DEV_ID),
      .CMD_MFR_ID (CMD_MFR_ID),
      .DEV_ID_VAL (DEV_ID_VAL),
      .MFR_ID_VAL (MFR_ID_VAL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .cmd_i     (cmd),
      .wdata_i   (wdata),
      .rd_data_o (rd_data),
      .regs_o    (regs_o)
   );

endmodule

// File: tb/tb_smb_slave_regs.sv
`timescale 1ns/1ps
module tb_smb_slave_regs;
   localparam int NREG = 4;
   localparam int Q    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [NREG*16-1:0] regs;

   assign sda_line = sda_m & ~sda_oe;

   always #2.5 clk = ~clk;

   smb_slave_regs #(.NUM_REGS(NREG)) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (sda_line),
      .sda_drive_low_o (sda_oe),
      .regs_o          (regs)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit in_stop = 0;
   bit bus_idle = 1;
   logic [15:0] mreg [NREG];
   bit pend_valid = 0;
   logic [7:0]  pend_idx;
   logic [15:0] pend_data;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_known(input logic [7:0] c);
      return (int'(c) < NREG) || c == 8'hFE || c == 8'hFF;
   endfunction

   function automatic logic [15:0] m_read(input logic [7:0] c);
      if (c == 8'hFE) return 16'h0006;
      if (c == 8'hFF) return 16'h004D;
      return mreg[c[1:0]];
   endfunction

   // per-clock comparison with the model
   always @(negedge clk) begin
      if (rst_n && !in_stop && !done) begin
         for (int i = 0; i < NREG; i++)
            check(regs[i*16 +: 16] == mreg[i], "R4", "register output vs model",
                  regs[i*16 +: 16], mreg[i]);
         if (bus_idle) check(sda_oe == 1'b0, "R12", "idle drive", sda_oe, 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      bus_idle = 0;
      pend_valid = 0;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      in_stop = 1;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
      if (pend_valid && int'(pend_idx) < NREG) mreg[pend_idx[1:0]] = pend_data;
      pend_valid = 0;
      in_stop = 0;
      bus_idle = 1;
      tick(Q);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(Q);
      s = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic write_byte(input logic [7:0] b, input bit glitch, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         if (glitch && i == 3) begin
            scl_m = 1'b1; tick(2);
            scl_m = 1'b0; tick(Q);
         end
         clk_bit(b[i], s);
      end
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(!mack, s);
   endtask

   task automatic write_word(input logic [6:0] a7, input logic [7:0] cmd,
                             input logic [15:0] data, input bit glitch);
      bit a;
      bus_start();
      write_byte({a7, 1'b0}, 0, a);
      check(a == (a7 == 7'h09), "R1", "address ack", a, a7 == 7'h09);
      if (a7 != 7'h09) begin
         write_byte(cmd, 0, a);
         check(!a, "R1", "byte after foreign address", a, 0);
         bus_stop();
         return;
      end
      write_byte(cmd, 0, a);
      check(a == m_known(cmd), "R9", "command ack", a, m_known(cmd));
      if (!m_known(cmd)) begin
         write_byte(data[7:0], 0, a);
         check(!a, "R9", "data after unknown command", a, 0);
         bus_stop();
         return;
      end
      write_byte(data[7:0], glitch, a);
      check(a, glitch ? "R11" : "R3", "low data ack", a, 1);
      write_byte(data[15:8], 0, a);
      check(a, "R3", "high data ack", a, 1);
      pend_valid = 1; pend_idx = cmd; pend_data = data;
      for (int i = 0; i < NREG; i++)
         check(regs[i*16 +: 16] == mreg[i], "R4", "unchanged before stop",
               regs[i*16 +: 16], mreg[i]);
      bus_stop();
   endtask

   task automatic read_word(input logic [7:0] cmd, input string req);
      bit a;
      logic [7:0] lo, hi;
      bus_start();
      write_byte(8'h12, 0, a);
      check(a, "R6", "read: write address ack", a, 1);
      write_byte(cmd, 0, a);
      check(a, "R6", "read: command ack", a, 1);
      bus_start();
      write_byte(8'h13, 0, a);
      check(a, "R6", "read: read address ack", a, 1);
      read_byte(1, lo);
      read_byte(0, hi);
      check({hi, lo} == m_read(cmd), req, "read word", {hi, lo}, m_read(cmd));
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) mreg[i] = 16'h0000;
      tick(10);
      check(sda_oe == 1'b0, "R12", "reset drive", sda_oe, 0);
      check(regs == '0, "R12", "reset registers", int'(regs[31:0]), 0);
      rst_n = 1'b1;
      tick(Q);

      // R2 R3 R4 R6: basic write then read, bit order patterns
      write_word(7'h09, 8'h01, 16'hA55A, 0);
      read_word(8'h01, "R6");
      write_word(7'h09, 8'h03, 16'h8001, 0);
      read_word(8'h03, "R2");
      write_word(7'h09, 8'h00, 16'hFFFF, 0);
      read_word(8'h00, "R6");
      read_word(8'h02, "R6");

      // R7 identity words
      read_word(8'hFE, "R7");
      read_word(8'hFF, "R7");

      // R8 writes to identity codes ignored
      write_word(7'h09, 8'hFE, 16'h1234, 0);
      write_word(7'h09, 8'hFF, 16'h5678, 0);
      read_word(8'hFE, "R8");
      read_word(8'hFF, "R8");

      // R1 foreign addresses
      write_word(7'h0A, 8'h01, 16'h0BAD, 0);
      write_word(7'h48, 8'h02, 16'h0BAD, 0);
      read_word(8'h01, "R1");

      // R9 unknown command
      write_word(7'h09, 8'h10, 16'hDEAD, 0);
      read_word(8'h00, "R9");

      // R5 repeated START discards staged word
      begin
         bit a;
         bus_start();
         write_byte(8'h12, 0, a); check(a, "R5", "addr ack", a, 1);
         write_byte(8'h02, 0, a); check(a, "R5", "cmd ack", a, 1);
         write_byte(8'hEF, 0, a); check(a, "R5", "lo ack", a, 1);
         write_byte(8'hBE, 0, a); check(a, "R5", "hi ack", a, 1);
         bus_start();
         write_byte(8'h12, 0, a); check(a, "R5", "addr ack after restart", a, 1);
         bus_stop();
         check(regs[2*16 +: 16] == 16'h0000, "R5", "discarded write", regs[2*16 +: 16], 0);
         read_word(8'h02, "R5");
      end

      // R10 read without command
      begin
         bit a;
         bus_start();
         write_byte(8'h13, 0, a);
         check(!a, "R10", "read without command", a, 0);
         bus_stop();
      end

      // R3 third data byte not acknowledged, word still applied
      begin
         bit a;
         bus_start();
         write_byte(8'h12, 0, a); check(a, "R3", "addr ack", a, 1);
         write_byte(8'h02, 0, a); check(a, "R3", "cmd ack", a, 1);
         write_byte(8'h34, 0, a); check(a, "R3", "lo ack", a, 1);
         write_byte(8'h12, 0, a); check(a, "R3", "hi ack", a, 1);
         pend_valid = 1; pend_idx = 8'h02; pend_data = 16'h1234;
         write_byte(8'h77, 0, a); check(!a, "R3", "extra byte nack", a, 0);
         bus_stop();
         read_word(8'h02, "R3");
      end

      // R11 short SCL glitch inside a byte
      write_word(7'h09, 8'h01, 16'h3C96, 1);
      read_word(8'h01, "R11");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog R12: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule